// File: doc/BRIEF.md
# Dual-Port Interrupt Gate

This block combines the interrupt requests of two disk ports into one shared card interrupt. Each port has an arm latch. The bus controls the latch by the type of access it makes, not by the data it carries. Any write to a port's arm address sets that port's latch, and a read of the same address clears it. The combined interrupt is asserted while any port is both armed and requesting.

Each port also has a status location. Bit 0 of that location shows the raw request from the drive, whether or not the port is armed. To route the interrupt to a single port, software writes that port's arm address and then reads the other port's arm address.

Bus accesses are single-cycle strobes. Read data is combinational while the read strobe is high. A read of an arm address returns the latch value that was present before the read clears it.

Top module: `irq_gate_top`

## Requirements
- R1: While reset is held and after reset is released, both arm latches are clear and `card_irq` is 0.
- R2: A write to a port's arm address (port 0 at 0x2200, port 1 at 0x3200) sets that port's latch at the clock edge, whatever value is on `bus_wdata`.
- R3: A read of a port's arm address returns the latch value in bit 0 of `rd_data`, with bits 7..1 at 0, and clears the latch at the clock edge.
- R4: A read of a port's status address (port 0 at 0x2290, port 1 at 0x3290) returns that port's raw request in bit 0, with bits 7..1 at 0.
- R5: Status bit 0 follows the raw request whether or not the port is armed.
- R6: `card_irq` is 1 exactly when some port is both armed and requesting.
- R7: An access to one port's arm address leaves the other port's latch unchanged.
- R8: An access to any other address changes no latch, and a read of it returns 0.
- R9: When the read and write strobes are both high on an arm address, the write takes precedence and the latch ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | Access address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data (has no effect on the block) |
| drv_irq | input | 2 | Raw interrupt request from each port |
| rd_data | output | 8 | Read data, valid while `bus_rd` is high |
| card_irq | output | 1 | Combined, gated card interrupt |

## Verification
The bench writes the value zero to an arm address. A design that decoded the data instead of the access type would then stay disarmed. The bench reads status while a port is disarmed, which catches a design that gates status with the latch. It reads an arm address to confirm that the old latch value comes back before the clear. It drives both strobes at once, where a design that favoured the read would leave the port disarmed. It accesses the other port and unmapped addresses to catch decode aliasing, where a single-port operation would wrongly change both latches or a stray access would flip one.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  // Arm address of a port: base plus one stride per port.
  function automatic logic [31:0] arm_addr(input logic [31:0] base,
                                           input logic [31:0] stride,
                                           input int ch);
    return base + stride * ch;
  endfunction

  // Status address of a port: its arm address plus a fixed offset.
  function automatic logic [31:0] stat_addr(input logic [31:0] base,
                                            input logic [31:0] stride,
                                            input logic [31:0] ofs,
                                            input int ch);
    return arm_addr(base, stride, ch) + ofs;
  endfunction
endpackage

// File: rtl/irqg_decode.sv
module irqg_decode
  import irq_gate_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int N_CH      = 2,
  parameter int EN_BASE   = 32'h2200,
  parameter int CH_STRIDE = 32'h1000,
  parameter int STAT_OFS  = 32'h0090
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [N_CH-1:0]   arm_hit,
  output logic [N_CH-1:0]   disarm_hit,
  output logic [N_CH-1:0]   arm_rd_sel,
  output logic [N_CH-1:0]   stat_rd_sel
);
  for (genvar ch = 0; ch < N_CH; ch++) begin : g_dec
    logic arm_match, stat_match;
    assign arm_match  = bus_addr == ADDR_W'(arm_addr(EN_BASE, CH_STRIDE, ch));
    assign stat_match = bus_addr == ADDR_W'(stat_addr(EN_BASE, CH_STRIDE, STAT_OFS, ch));
    assign arm_hit[ch]     = bus_wr && arm_match;
    assign disarm_hit[ch]  = bus_rd && !bus_wr && arm_match;
    assign arm_rd_sel[ch]  = bus_rd && arm_match;
    assign stat_rd_sel[ch] = bus_rd && stat_match;
  end
endmodule

// File: rtl/irqg_channel.sv
module irqg_channel (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic disarm,
  input  logic req,
  output logic armed,
  output logic gated
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed <= 1'b0;
    else if (arm)    armed <= 1'b1;
    else if (disarm) armed <= 1'b0;
  end

  assign gated = armed && req;

  assert_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> armed);
  assert_disarm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (disarm && !arm) |=> !armed);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && !disarm) |=> $stable(armed));
  assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gated |-> (armed && req));
endmodule

// File: rtl/irqg_rdmux.sv
module irqg_rdmux #(
  parameter int N_CH   = 2,
  parameter int DATA_W = 8
) (
  input  logic [N_CH-1:0]   arm_rd_sel,
  input  logic [N_CH-1:0]   stat_rd_sel,
  input  logic [N_CH-1:0]   armed,
  input  logic [N_CH-1:0]   req,
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    for (int ch = 0; ch < N_CH; ch++) begin
      if (arm_rd_sel[ch])  rd_data[0] = rd_data[0] | armed[ch];
      if (stat_rd_sel[ch]) rd_data[0] = rd_data[0] | req[ch];
    end
  end
endmodule

// File: rtl/irq_gate_top.sv
module irq_gate_top #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int N_CH      = 2,
  parameter int EN_BASE   = 32'h2200,
  parameter int CH_STRIDE = 32'h1000,
  parameter int STAT_OFS  = 32'h0090
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [N_CH-1:0]   drv_irq,
  output logic [DATA_W-1:0] rd_data,
  output logic              card_irq
);
  logic [N_CH-1:0] arm_hit, disarm_hit, arm_rd_sel, stat_rd_sel;
  logic [N_CH-1:0] armed, gated;
  logic            wdata_unused;

  assign wdata_unused = ^bus_wdata;

  irqg_decode #(
    .ADDR_W(ADDR_W), .N_CH(N_CH), .EN_BASE(EN_BASE),
    .CH_STRIDE(CH_STRIDE), .STAT_OFS(STAT_OFS)
  ) u_dec (
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .arm_hit(arm_hit), .disarm_hit(disarm_hit),
    .arm_rd_sel(arm_rd_sel), .stat_rd_sel(stat_rd_sel)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    irqg_channel u_ch (
      .clk(clk), .rst_n(rst_n),
      .arm(arm_hit[ch]), .disarm(disarm_hit[ch]),
      .req(drv_irq[ch]), .armed(armed[ch]), .gated(gated[ch])
    );
  end

  irqg_rdmux #(.N_CH(N_CH), .DATA_W(DATA_W)) u_rd (
    .arm_rd_sel(arm_rd_sel), .stat_rd_sel(stat_rd_sel),
    .armed(armed), .req(drv_irq), .rd_data(rd_data)
  );

  assign card_irq = |gated;

  assert_irq_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    card_irq |-> (|drv_irq));
  assert_rd_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (rd_data == '0));
  assert_rd_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:1] == '0);
  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |-> !card_irq);
endmodule

// File: tb/test_irq_gate_top.sv
module test_irq_gate_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [1:0]  drv_irq = '0;
  logic [7:0]  rd_data;
  logic        card_irq;

  int checks = 0, errors = 0;
  logic [1:0] m_en = '0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_gate_top i_irq_gate_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .drv_irq(drv_irq),
    .rd_data(rd_data), .card_irq(card_irq)
  );

  function automatic int port_of_arm(input logic [15:0] a);
    if (a == 16'h2200) return 0;
    if (a == 16'h3200) return 1;
    return -1;
  endfunction

  function automatic int port_of_stat(input logic [15:0] a);
    if (a == 16'h2290) return 0;
    if (a == 16'h3290) return 1;
    return -1;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [15:0] a, input logic rd,
                                        input logic [1:0] en, input logic [1:0] rq);
    int p = port_of_arm(a);
    int s = port_of_stat(a);
    if (!rd) return 8'h00;
    if (p >= 0) return {7'd0, en[p]};
    if (s >= 0) return {7'd0, rq[s]};
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input string req, input logic [15:0] a, input logic wr,
                     input logic rd, input logic [7:0] d, input logic [1:0] rq);
    int p;
    @(negedge clk);
    bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = d; drv_irq = rq;
    #2;
    check(req, rd_data, exp_rd(a, rd, m_en, rq));
    @(posedge clk);
    p = port_of_arm(a);
    if (p >= 0) begin
      if (wr) m_en[p] = 1'b1;
      else if (rd) m_en[p] = 1'b0;
    end
    #2;
    check(req, {7'd0, card_irq}, {7'd0, |(m_en & rq)});
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] addrs [6];
    void'($urandom(32'd1234));
    addrs = '{16'h2200, 16'h3200, 16'h2290, 16'h3290, 16'h2204, 16'h3280};
    drv_irq = 2'b11;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset", {7'd0, card_irq}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    cyc("R1 after reset", 16'h2200, 1'b0, 1'b1, 8'h00, 2'b11);
    cyc("R1 after reset", 16'h3200, 1'b0, 1'b1, 8'h00, 2'b11);
    // R2: write of zero still arms
    cyc("R2 arm with zero data", 16'h2200, 1'b1, 1'b0, 8'h00, 2'b01);
    cyc("R6 armed port 0", 16'h0000, 1'b0, 1'b0, 8'h00, 2'b01);
    cyc("R7 other port unarmed", 16'h0000, 1'b0, 1'b0, 8'h00, 2'b10);
    // R5: status while disarmed
    cyc("R5 status unarmed", 16'h3290, 1'b0, 1'b1, 8'h00, 2'b10);
    cyc("R4 status port 0", 16'h2290, 1'b0, 1'b1, 8'h00, 2'b01);
    // R8: stray access
    cyc("R8 stray write", 16'h3204, 1'b1, 1'b0, 8'hFF, 2'b11);
    cyc("R8 stray read", 16'h2280, 1'b0, 1'b1, 8'h00, 2'b11);
    // select port 1 only
    cyc("R2 arm port 1", 16'h3200, 1'b1, 1'b0, 8'hA5, 2'b11);
    cyc("R3 read old latch and clear", 16'h2200, 1'b0, 1'b1, 8'h00, 2'b01);
    cyc("R3 port 0 cleared", 16'h2200, 1'b0, 1'b1, 8'h00, 2'b01);
    cyc("R7 port 1 still armed", 16'h3200, 1'b0, 1'b1, 8'h00, 2'b10);
    // R9: both strobes
    cyc("R9 write wins", 16'h2200, 1'b1, 1'b1, 8'h00, 2'b01);
    cyc("R9 latch set", 16'h0000, 1'b0, 1'b0, 8'h00, 2'b01);
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      int k = $urandom_range(0, 7);
      a = (k < 6) ? addrs[k] : 16'($urandom);
      cyc("R6 random", a, 1'($urandom), 1'($urandom), 8'($urandom), 2'($urandom));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule